// File: doc/BRIEF.md
# Request Packet Header Builder

The block turns a single user request into a simplified transaction-layer request packet. A one-cycle start strobe captures a 32-bit byte address, a byte count, a request kind (memory read, memory write, IO read or IO write) and a packed block of write data. From the unaligned address and the byte count the block derives the packet length in doublewords and the byte-enable masks for the first and last doublewords. It then streams the result, one 32-bit word per accepted beat, to a link-layer transmitter over a valid/ready interface.

A read produces three header words. A write produces the same three header words followed by its payload words. The block rejects an unsupported request with a one-cycle error pulse and sends nothing for it. While a packet is in flight the block reports busy and ignores any further start strobe.

Top module: `req_pkt_builder`

## Requirements
- R1: After reset, tx_valid_o, tx_last_o, busy_o and err_o are all 0.
- R2: The length in doublewords is ceil((addr_i[1:0] + byte_len_i) / 4). Header word 0 is {fmt[2:0], type[4:0], 14'b0, len_dw[9:0]}. The codes are: kind_i 0 (memory read) gives fmt 000 / type 00000, kind_i 1 (memory write) gives 010 / 00000, kind_i 2 (IO read) gives 000 / 00010, and kind_i 3 (IO write) gives 010 / 00010.
- R3: Header word 1 carries the first byte enable in bits [3:0]. Bit b is set when b >= addr_i[1:0]. When the length is one doubleword, bit b must also satisfy b < addr_i[1:0] + byte_len_i.
- R4: Header word 1 carries the last byte enable in bits [7:4] and is 0 in bits [31:8]. This field is 4'b0000 for a one-doubleword request. Otherwise it enables lanes 0 through ((addr_i[1:0] + byte_len_i - 1) mod 4).
- R5: Header word 2 is {addr_i[31:2], 2'b00}.
- R6: A read emits exactly three beats. tx_last_o is set only on the final beat.
- R7: A write emits the header and then len_dw payload words. Payload word i is wdata_i[32*i +: 32].
- R8: An IO request longer than one doubleword produces a one-cycle err_o pulse in the cycle after the strobe and emits no packet.
- R9: A request with byte_len_i of 0, or with a length above MAX_DW doublewords, is rejected in the same way as in R8.
- R10: busy_o is high from the cycle after an accepted strobe until the final beat is accepted. A start_i pulse while busy_o is high has no effect on the packet in flight and does not start a new packet.
- R11: While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_data_o and tx_last_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request strobe |
| addr_i | input | 32 | Byte address of the request |
| byte_len_i | input | LEN_W (5) | Byte count |
| kind_i | input | 2 | Request kind: 0 memory read, 1 memory write, 2 IO read, 3 IO write |
| wdata_i | input | 32*MAX_DW (128) | Write payload words, word 0 in the low bits |
| tx_ready_i | input | 1 | Link layer accepts a beat |
| tx_valid_o | output | 1 | Beat valid |
| tx_data_o | output | 32 | Beat word |
| tx_last_o | output | 1 | Final beat of the packet |
| busy_o | output | 1 | Packet in flight |
| err_o | output | 1 | Request rejected (one-cycle pulse) |

## Verification
A wrong length or byte-enable computation appears at the ports as a mismatched header word 0 or word 1. It is visible within one or two beats of the strobe. A wrong beat counter appears on tx_last_o or on the payload words in the same packet, and it also shows up as a busy_o that lasts too long or ends too early after the final handshake. A faulty start qualifier or reject decode shows up the cycle after the strobe, through err_o, a missing first beat, or a packet that should not exist.

// File: rtl/reqbuild_pkg.sv
package reqbuild_pkg;
  typedef enum logic [1:0] {
    KIND_MRD  = 2'd0,
    KIND_MWR  = 2'd1,
    KIND_IORD = 2'd2,
    KIND_IOWR = 2'd3
  } req_kind_e;

  typedef struct packed {
    logic [2:0]  fmt;
    logic [4:0]  typ;
    logic [9:0]  len_dw;
    logic [3:0]  first_be;
    logic [3:0]  last_be;
    logic [29:0] dw_addr;
    logic        has_data;
  } req_hdr_t;

  localparam int unsigned HDR_DW = 3;
endpackage

// File: rtl/reqbuild_calc.sv
module reqbuild_calc
  import reqbuild_pkg::*;
#(
  parameter int unsigned MAX_DW = 4,
  parameter int unsigned LEN_W  = 5
) (
  input  logic [31:0]      addr_i,
  input  logic [LEN_W-1:0] byte_len_i,
  input  logic [1:0]       kind_i,
  output req_hdr_t         hdr_o,
  output logic             reject_o
);
  localparam int unsigned SPAN_W = LEN_W + 2;

  logic [SPAN_W-1:0] span, len_dw;
  logic              single;
  logic [1:0]        end_lane;

  always_comb begin
    span     = SPAN_W'(addr_i[1:0]) + SPAN_W'(byte_len_i);
    len_dw   = (span + SPAN_W'(3)) >> 2;
    single   = (len_dw == SPAN_W'(1));
    end_lane = span[1:0];
    hdr_o.fmt      = kind_i[0] ? 3'b010 : 3'b000;
    hdr_o.typ      = kind_i[1] ? 5'b00010 : 5'b00000;
    hdr_o.len_dw   = 10'(len_dw);
    hdr_o.dw_addr  = addr_i[31:2];
    hdr_o.has_data = kind_i[0];
    for (int b = 0; b < 4; b++) begin
      hdr_o.first_be[b] = (2'(b) >= addr_i[1:0]) && (!single || (SPAN_W'(b) < span));
      hdr_o.last_be[b]  = !single && ((end_lane == 2'd0) || (2'(b) < end_lane));
    end
    // zero length, oversize, or multi-doubleword IO
    reject_o = (byte_len_i == '0) || (len_dw > SPAN_W'(MAX_DW)) || (kind_i[1] && !single);
  end
endmodule

// File: rtl/reqbuild_stream.sv
module reqbuild_stream
  import reqbuild_pkg::*;
#(
  parameter int unsigned MAX_DW = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  req_hdr_t            hdr_i,
  input  logic [32*MAX_DW-1:0] wdata_i,
  input  logic                tx_ready_i,
  output logic                tx_valid_o,
  output logic [31:0]         tx_data_o,
  output logic                tx_last_o,
  output logic                busy_o
);
  localparam int unsigned BEAT_W = $clog2(MAX_DW + HDR_DW + 1);
  localparam int unsigned IDX_W  = (MAX_DW > 1) ? $clog2(MAX_DW) : 1;

  req_hdr_t          hdr_q;
  logic [31:0]       pay_q [MAX_DW];
  logic [BEAT_W-1:0] beat_q, total;
  logic              active_q;
  logic [31:0]       hdr_w [HDR_DW];

  assign hdr_w[0] = {hdr_q.fmt, hdr_q.typ, 14'b0, hdr_q.len_dw};
  assign hdr_w[1] = {24'b0, hdr_q.last_be, hdr_q.first_be};
  assign hdr_w[2] = {hdr_q.dw_addr, 2'b00};

  assign total = BEAT_W'(HDR_DW) + (hdr_q.has_data ? BEAT_W'(hdr_q.len_dw) : '0);

  always_comb begin
    if (beat_q < BEAT_W'(HDR_DW)) tx_data_o = hdr_w[beat_q[1:0]];
    else                          tx_data_o = pay_q[IDX_W'(beat_q - BEAT_W'(HDR_DW))];
  end

  assign tx_valid_o = active_q;
  assign busy_o     = active_q;
  assign tx_last_o  = active_q && (beat_q == total - BEAT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      hdr_q    <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      beat_q   <= '0;
      hdr_q    <= hdr_i;
    end else if (active_q && tx_ready_i) begin
      beat_q <= beat_q + BEAT_W'(1);
      if (tx_last_o) active_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < MAX_DW; i++) begin : g_pay
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pay_q[i] <= '0;
      else if (load_i) pay_q[i] <= wdata_i[32*i +: 32];
    end
  end
endmodule

// File: rtl/req_pkt_builder.sv
module req_pkt_builder
  import reqbuild_pkg::*;
#(
  parameter int unsigned MAX_DW = 4,
  parameter int unsigned LEN_W  = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [31:0]          addr_i,
  input  logic [LEN_W-1:0]     byte_len_i,
  input  logic [1:0]           kind_i,
  input  logic [32*MAX_DW-1:0] wdata_i,
  input  logic                 tx_ready_i,
  output logic                 tx_valid_o,
  output logic [31:0]          tx_data_o,
  output logic                 tx_last_o,
  output logic                 busy_o,
  output logic                 err_o
);
  req_hdr_t hdr;
  logic     reject, accept;

  reqbuild_calc #(.MAX_DW(MAX_DW), .LEN_W(LEN_W)) u_calc (
    .addr_i     (addr_i),
    .byte_len_i (byte_len_i),
    .kind_i     (kind_i),
    .hdr_o      (hdr),
    .reject_o   (reject)
  );

  assign accept = start_i && !busy_o;

  reqbuild_stream #(.MAX_DW(MAX_DW)) u_stream (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept && !reject),
    .hdr_i      (hdr),
    .wdata_i    (wdata_i),
    .tx_ready_i (tx_ready_i),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .tx_last_o  (tx_last_o),
    .busy_o     (busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= accept && reject;
  end
endmodule

// File: rtl/req_pkt_builder_chk.sv
module req_pkt_builder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        tx_ready_i,
  input logic        tx_valid_o,
  input logic [31:0] tx_data_o,
  input logic        tx_last_o,
  input logic        busy_o,
  input logic        err_o
);
  // R11
  hold_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));
  // R6
  last_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_last_o |-> tx_valid_o);
  // R8
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);
  // R10
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R10
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !(tx_last_o && tx_ready_i) |=> busy_o);
endmodule

bind req_pkt_builder req_pkt_builder_chk u_chk (.*);

// File: tb/req_pkt_builder_tb_top.sv
module req_pkt_builder_tb_top;
  localparam int MAX_DW = 4;
  localparam int LEN_W  = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ready = 1'b0;
  logic [31:0] addr = '0;
  logic [LEN_W-1:0] blen = '0;
  logic [1:0] kind = '0;
  logic [32*MAX_DW-1:0] wdata = '0;
  logic tx_valid, tx_last, busy, err;
  logic [31:0] tx_data;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] exp_w [8];
  int exp_n;
  bit exp_err;

  always #10 clk = ~clk;

  req_pkt_builder #(.MAX_DW(MAX_DW), .LEN_W(LEN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .byte_len_i(blen),
    .kind_i(kind), .wdata_i(wdata), .tx_ready_i(ready), .tx_valid_o(tx_valid),
    .tx_data_o(tx_data), .tx_last_o(tx_last), .busy_o(busy), .err_o(err));

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // reference model from the requirements
  task automatic model(logic [31:0] a, int len, logic [1:0] k, logic [127:0] wd);
    int off = a[1:0];
    int span = off + len;
    int ldw = (span + 3) / 4;
    logic [3:0] fbe, lbe;
    for (int b = 0; b < 4; b++) begin
      fbe[b] = (b >= off) && (ldw > 1 || b < span);
      lbe[b] = (ldw > 1) && (b <= (span - 1) % 4);
    end
    exp_err = (len == 0) || (ldw > MAX_DW) || (k[1] && ldw > 1);
    exp_w[0] = {(k[0] ? 3'b010 : 3'b000), (k[1] ? 5'b00010 : 5'b00000), 14'b0, 10'(ldw)};
    exp_w[1] = {24'b0, lbe, fbe};
    exp_w[2] = {a[31:2], 2'b00};
    exp_n = 3;
    if (k[0] && !exp_err) begin
      for (int i = 0; i < ldw; i++) exp_w[3+i] = wd[32*i +: 32];
      exp_n = 3 + ldw;
    end
  endtask

  task automatic send(logic [31:0] a, int len, logic [1:0] k, logic [127:0] wd,
                      int ready_pct, bit inject);
    int beat = 0, guard = 0;
    string tag;
    model(a, len, k, wd);
    @(negedge clk);
    start = 1'b1; addr = a; blen = LEN_W'(len); kind = k; wdata = wd;
    @(negedge clk);
    start = 1'b0; addr = ~a; blen = '1; kind = ~k; wdata = ~wd;
    if (exp_err) begin
      chk(err === 1'b1, "R8/R9 err pulse", {31'b0, err}, 32'd1);
      chk(tx_valid === 1'b0 && busy === 1'b0, "R8/R9 no packet", {31'b0, tx_valid}, 32'd0);
      @(negedge clk);
      chk(err === 1'b0 && tx_valid === 1'b0, "R8 one-cycle pulse", {31'b0, err}, 32'd0);
      return;
    end
    chk(err === 1'b0, "R9 no err", {31'b0, err}, 32'd0);
    chk(busy === 1'b1, "R10 busy", {31'b0, busy}, 32'd1);
    while (beat < exp_n && guard < 200) begin
      guard++;
      ready = ($urandom_range(99) < ready_pct);
      if (inject && beat == 1) begin
        start = 1'b1; addr = 32'h5555_5551; blen = 5'd1; kind = 2'd1;
      end else start = 1'b0;
      chk(tx_valid === 1'b1, "R11 valid held", {31'b0, tx_valid}, 32'd1);
      if (tx_valid && ready) begin
        tag = (beat == 0) ? "R2 word0" : (beat == 1) ? "R3/R4 word1" :
              (beat == 2) ? "R5 word2" : "R7 payload";
        chk(tx_data === exp_w[beat], tag, tx_data, exp_w[beat]);
        chk(tx_last === (beat == exp_n - 1), "R6 last flag", {31'b0, tx_last},
            {31'b0, beat == exp_n - 1});
        beat++;
      end
      @(negedge clk);
    end
    start = 1'b0; ready = 1'b0;
    chk(busy === 1'b0 && tx_valid === 1'b0, "R10 idle after last", {31'b0, busy}, 32'd0);
    if (inject) begin
      @(negedge clk);
      chk(tx_valid === 1'b0 && err === 1'b0, "R10 ignored start", {31'b0, tx_valid}, 32'd0);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk(tx_valid === 1'b0 && busy === 1'b0 && err === 1'b0 && tx_last === 1'b0,
        "R1 reset", {28'b0, tx_valid, tx_last, busy, err}, 32'd0);
    #45 rst_n = 1'b1;
    @(negedge clk);
    chk(tx_valid === 1'b0 && busy === 1'b0 && err === 1'b0,
        "R1 after reset", {29'b0, tx_valid, busy, err}, 32'd0);
    // directed corners
    send(32'h1000_0003, 1, 2'd0, '0, 100, 0);       // R3 single byte lane 3
    send(32'h1000_0001, 2, 2'd1, rnd128(), 100, 0); // R3 mid lanes
    send(32'h2000_0002, 4, 2'd1, rnd128(), 50, 0);  // R4 spans two dw
    send(32'h3000_0000, 16, 2'd1, rnd128(), 30, 0); // R7 max payload
    send(32'h3000_0001, 16, 2'd1, rnd128(), 100, 0);// R9 too long
    send(32'h4000_0000, 0, 2'd0, '0, 100, 0);       // R9 zero length
    send(32'h5000_0002, 3, 2'd3, rnd128(), 100, 0); // R8 IO crosses dw
    send(32'h5000_0000, 4, 2'd2, '0, 100, 0);       // R2 IO read full dw
    send(32'h5000_0001, 2, 2'd3, rnd128(), 40, 0);  // R2 IO write
    send(32'h6000_0001, 7, 2'd1, rnd128(), 60, 1);  // R10 ignored strobe
    send(32'h7000_0000, 8, 2'd0, '0, 20, 1);        // R11 heavy backpressure
    for (int n = 0; n < 300; n++)
      send($urandom, int'($urandom_range(0, 20)), 2'($urandom_range(3)), rnd128(),
           int'($urandom_range(20, 100)), ($urandom_range(9) == 0));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule